// File: doc/BRIEF.md
# Challenge-Response Window Watchdog

This block supervises a host processor from outside it. The host must service the watchdog once in every period, and only in the second half of that period. Each service is an 8-bit answer. The answer has to match a value derived from an 8-bit pseudo-random challenge, which the host can read at any time. The host loads the challenge generator with a seed of its choosing. After every accepted answer the generator moves to its next value, so a processor that has stopped running its software cannot keep replaying one stored answer.

Each period is tracked by a two-state machine. `PH_SHUT` covers the closed first half and `PH_OPEN` covers the open second half. The transition `SHUT_TO_OPEN` fires when the tick count reaches half the period. The transition `EXPIRE` goes from `PH_OPEN` back to `PH_SHUT` when the period runs out with no answer. The transition `KICK` goes from either state back to `PH_SHUT` whenever an answer is written. Each attempt produces a verdict one cycle later: a single-cycle good pulse or a single-cycle bad pulse. A timeout produces a bad pulse and, in the same cycle, a timeout pulse. The escalation counters that act on these pulses sit outside this block.

Top module: `chal_wdog`

## Requirements
- R1: While reset is held, and in the first cycle after it, `challenge` equals the INIT_SEED parameter (default 0x5A). In that state `window_open` is low and no pulse is high. The first period is INIT_PERIOD ticks long (default 8).
- R2: A seed write loads `seed_val` into `challenge`, and the new value is visible one cycle later. If a seed write and an accepted answer fall in the same cycle, the seed wins.
- R3: One step of the challenge shifts it left by one bit and drops the top bit. The new bit 0 is the XNOR of bit 3 with the XNOR of bit 4 with the XNOR of bits 7 and 5. A challenge of 0xFF therefore maps to itself.
- R4: The expected answer is computed from the challenge C in this order: 4*C, plus 6, minus 4, bitwise inverted, masked to 16 bits, divided by 4 with the remainder dropped, then truncated to 8 bits.
- R5: A period of P ticks is closed for its first floor(P/2) ticks and open for the rest. `window_open` shows the phase. P is sampled from `cfg_period` each time a period restarts. Values below 2 are treated as 2.
- R6: If the correct answer is written while the window is open, `good_pulse` is high for exactly the next cycle and `challenge` steps once.
- R7: If a wrong answer is written while the window is open, `bad_pulse` is high for the next cycle and `challenge` is unchanged.
- R8: Any answer written while the window is closed gives `bad_pulse` on the next cycle. This holds even if the answer is correct, and `challenge` does not change.
- R9: If the open half runs out with no answer, `bad_pulse` and `timeout_pulse` are both high for one cycle. A new period starts closed in that same cycle.
- R10: Every answer write, good or bad, starts a fresh closed period. The period restarts on the clock edge that accepts the write.
- R11: `good_pulse` and `bad_pulse` are never high together, and `timeout_pulse` is only ever high together with `bad_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | PW | Period length in ticks, sampled at each restart |
| seed_we | input | 1 | Seed write strobe |
| seed_val | input | 8 | Seed value |
| ans_we | input | 1 | Answer write strobe |
| ans_val | input | 8 | Answer value |
| challenge | output | 8 | Current challenge |
| window_open | output | 1 | High during the open half |
| good_pulse | output | 1 | Accepted refresh, one cycle |
| bad_pulse | output | 1 | Rejected refresh or timeout, one cycle |
| timeout_pulse | output | 1 | Period ran out with no answer, one cycle |

## Verification
The bench first sweeps the configured period from 0 to 9. For each period it writes a correct answer at every tick offset from the start of the period to one past its end. This separates the closed-half rejection from the open-half acceptance at the exact boundary tick, and it catches the expiry at the end of the period. A wrong answer written inside the open window separates a content check from a timing check. The bench then sweeps all 256 seeds, answering correctly twice after each one. This exercises both the stepping rule and the answer transform over the whole challenge space, including the 0xFF fixed point. A seed write in the same cycle as a good answer shows which of the two takes priority.

// File: rtl/chal_wdog_pkg.sv
package chal_wdog_pkg;

    localparam int CW = 8;

    typedef enum logic [0:0] {
        PH_SHUT = 1'b0,
        PH_OPEN = 1'b1
    } phase_t;

    // One step of the challenge generator: shift left, chained XNOR feedback.
    function automatic logic [CW-1:0] lfsr_step(input logic [CW-1:0] v);
        logic g;
        g = ~(v[7] ^ v[5]);
        g = ~(v[4] ^ g);
        g = ~(v[3] ^ g);
        return {v[CW-2:0], g};
    endfunction

    // Arithmetic transform that the host must apply to the challenge.
    function automatic logic [CW-1:0] answer_of(input logic [CW-1:0] v);
        logic [31:0] acc;
        acc = {24'd0, v} * 32'd4;
        acc = acc + 32'd6;
        acc = acc - 32'd4;
        acc = ~acc;
        acc = acc & 32'h0000_FFFF;
        acc = acc / 32'd4;
        return acc[CW-1:0];
    endfunction

endpackage

// File: rtl/cw_challenge.sv
module cw_challenge
    import chal_wdog_pkg::*;
#(
    parameter logic [CW-1:0] INIT_SEED = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic [CW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= INIT_SEED;
        else if (load)
            q <= load_val;
        else if (step)
            q <= lfsr_step(q);
    end

    // R7
    hold_without_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(q));

    // R2
    seed_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));

endmodule

// File: rtl/cw_window.sv
module cw_window
    import chal_wdog_pkg::*;
#(
    parameter int PW          = 8,
    parameter int INIT_PERIOD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic          kick,
    output logic          is_open,
    output logic          expire
);

    localparam logic [PW-1:0] MIN_P  = PW'(2);
    localparam logic [PW-1:0] INIT_P = (INIT_PERIOD < 2) ? MIN_P : PW'(INIT_PERIOD);

    function automatic logic [PW-1:0] clamp_p(input logic [PW-1:0] c);
        return (c < MIN_P) ? MIN_P : c;
    endfunction

    phase_t        ph, ph_nxt;
    logic [PW-1:0] cnt, cnt_nxt;
    logic [PW-1:0] per_q;
    logic [PW-1:0] half;
    logic          restart;

    assign half    = per_q >> 1;
    assign expire  = (ph == PH_OPEN) && (cnt == per_q - 1'b1) && !kick;
    assign restart = kick | expire;

    // next-state logic
    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt + 1'b1;
        if (restart) begin
            ph_nxt  = PH_SHUT;
            cnt_nxt = '0;
        end else begin
            unique case (ph)
                PH_SHUT: if (cnt + 1'b1 == half) ph_nxt = PH_OPEN;
                PH_OPEN: ph_nxt = PH_OPEN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= PH_SHUT;
            cnt   <= '0;
            per_q <= INIT_P;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
            if (restart)
                per_q <= clamp_p(cfg_period);
        end
    end

    // outputs
    always_comb begin
        unique case (ph)
            PH_SHUT: is_open = 1'b0;
            PH_OPEN: is_open = 1'b1;
        endcase
    end

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_q);

    // R10
    restart_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !is_open);

endmodule

// File: rtl/cw_verdict.sv
module cw_verdict
    import chal_wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ans_we,
    input  logic [CW-1:0] ans_val,
    input  logic [CW-1:0] expect_val,
    input  logic          is_open,
    input  logic          expire,
    output logic          step,
    output logic          good_q,
    output logic          bad_q,
    output logic          to_q
);

    logic match;

    assign match = (ans_val == expect_val);
    assign step  = ans_we && is_open && match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= 1'b0;
            bad_q  <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            good_q <= step;
            bad_q  <= (ans_we && !step) || expire;
            to_q   <= expire;
        end
    end

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_q && bad_q));

    // R11
    timeout_is_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_q |-> bad_q);

    // R6
    good_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_q |-> $past(is_open && ans_we));

    // R8
    closed_write_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_we && !is_open) |=> bad_q);

endmodule

// File: rtl/chal_wdog.sv
module chal_wdog
    import chal_wdog_pkg::*;
#(
    parameter int             PW          = 8,
    parameter int             INIT_PERIOD = 8,
    parameter logic [CW-1:0]  INIT_SEED   = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic          seed_we,
    input  logic [7:0]    seed_val,
    input  logic          ans_we,
    input  logic [7:0]    ans_val,
    output logic [7:0]    challenge,
    output logic          window_open,
    output logic          good_pulse,
    output logic          bad_pulse,
    output logic          timeout_pulse
);

    logic          step;
    logic          expire;
    logic [CW-1:0] expect_val;

    assign expect_val = answer_of(challenge);

    cw_challenge #(.INIT_SEED(INIT_SEED)) i_chal (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_we),
        .load_val (seed_val),
        .step     (step),
        .q        (challenge)
    );

    cw_window #(.PW(PW), .INIT_PERIOD(INIT_PERIOD)) i_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .kick       (ans_we),
        .is_open    (window_open),
        .expire     (expire)
    );

    cw_verdict i_verd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ans_we     (ans_we),
        .ans_val    (ans_val),
        .expect_val (expect_val),
        .is_open    (window_open),
        .expire     (expire),
        .step       (step),
        .good_q     (good_pulse),
        .bad_q      (bad_pulse),
        .to_q       (timeout_pulse)
    );

endmodule

// File: tb/test_chal_wdog.sv
`timescale 1ns/1ps
module test_chal_wdog;

    localparam int         PW          = 8;
    localparam int         INIT_PERIOD = 8;
    localparam logic [7:0] INIT_SEED   = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] cfg_period = PW'(INIT_PERIOD);
    logic          seed_we = 1'b0;
    logic [7:0]    seed_val = '0;
    logic          ans_we = 1'b0;
    logic [7:0]    ans_val = '0;
    logic [7:0]    challenge;
    logic          window_open, good_pulse, bad_pulse, timeout_pulse;

    always #2.5 clk = ~clk;

    chal_wdog #(.PW(PW), .INIT_PERIOD(INIT_PERIOD), .INIT_SEED(INIT_SEED)) i_chal_wdog (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .seed_we(seed_we), .seed_val(seed_val),
        .ans_we(ans_we), .ans_val(ans_val),
        .challenge(challenge), .window_open(window_open),
        .good_pulse(good_pulse), .bad_pulse(bad_pulse), .timeout_pulse(timeout_pulse)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    int         m_t;
    int         m_P;
    logic [7:0] m_L;
    bit         e_good, e_bad, e_to, e_open;

    function automatic logic [7:0] b_next(input logic [7:0] v);
        return {v[6:0], ~(^(v & 8'hB8))};
    endfunction

    function automatic logic [7:0] b_ans(input logic [7:0] v);
        int x;
        x = int'(v) * 4 + 6 - 4;
        x = (~x) & 'hFFFF;
        x = x / 4;
        return x[7:0];
    endfunction

    function automatic int b_clamp(input int c);
        return (c < 2) ? 2 : c;
    endfunction

    task automatic compare();
        bit bad = 1'b0;
        vectors++;
        if (challenge !== m_L) begin
            bad = 1'b1;
            $display("FAIL %s challenge actual=%h expected=%h", tag, challenge, m_L);
        end
        if (window_open !== e_open) begin
            bad = 1'b1;
            $display("FAIL %s window_open actual=%b expected=%b", tag, window_open, e_open);
        end
        if (good_pulse !== e_good) begin
            bad = 1'b1;
            $display("FAIL %s good_pulse actual=%b expected=%b", tag, good_pulse, e_good);
        end
        if (bad_pulse !== e_bad) begin
            bad = 1'b1;
            $display("FAIL %s bad_pulse actual=%b expected=%b", tag, bad_pulse, e_bad);
        end
        if (timeout_pulse !== e_to) begin
            bad = 1'b1;
            $display("FAIL %s timeout_pulse actual=%b expected=%b", tag, timeout_pulse, e_to);
        end
        if (good_pulse && bad_pulse) begin  // R11
            bad = 1'b1;
            $display("FAIL R11 good&bad actual=1 expected=0");
        end
        if (bad) miscompares++;
    endtask

    // one clock: drive inputs, advance the model, sample after the edge
    task automatic cyc(input bit aw, input logic [7:0] av, input bit sw, input logic [7:0] sv);
        bit open_now;
        logic [7:0] nl;
        ans_we = aw; ans_val = av; seed_we = sw; seed_val = sv;
        open_now = (m_t >= m_P / 2);
        e_good = 1'b0; e_bad = 1'b0; e_to = 1'b0;
        nl = m_L;
        if (aw) begin
            e_good = open_now && (av == b_ans(m_L));
            e_bad  = !e_good;
            if (e_good) nl = b_next(m_L);
            m_t = 0;
            m_P = b_clamp(int'(cfg_period));
        end else if (open_now && m_t == m_P - 1) begin
            e_bad = 1'b1;
            e_to  = 1'b1;
            m_t = 0;
            m_P = b_clamp(int'(cfg_period));
        end else begin
            m_t++;
        end
        if (sw) nl = sv;
        m_L = nl;
        e_open = (m_t >= m_P / 2);
        @(posedge clk);
        #1;
        ans_we = 1'b0; seed_we = 1'b0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic wait_open();
        for (int i = 0; i < 300 && m_t < m_P / 2; i++) idle(1);
    endtask

    initial begin
        m_t = 0; m_P = b_clamp(INIT_PERIOD); m_L = INIT_SEED;
        e_good = 0; e_bad = 0; e_to = 0; e_open = 0;
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        compare();
        rst_n = 1'b1;
        // first period: timeout after INIT_PERIOD ticks
        tag = "R9";
        idle(INIT_PERIOD + 2);

        // period and timing sweep
        for (int p = 0; p <= 9; p++) begin
            cfg_period = PW'(p);
            tag = "R5";
            for (int i = 0; i < 40 && !e_to; i++) idle(1);
            tag = "R9";
            idle(m_P);
            for (int d = 0; d <= m_P; d++) begin
                tag = (d < m_P / 2) ? "R8" : "R6";
                idle(d);
                cyc(1'b1, b_ans(m_L), 1'b0, 8'h00);
                tag = "R10";
                idle(1);
            end
            tag = "R7";
            wait_open();
            cyc(1'b1, b_ans(m_L) ^ 8'h01, 1'b0, 8'h00);
            idle(1);
        end

        // seed sweep across the whole challenge space
        cfg_period = PW'(4);
        for (int s = 0; s < 256; s++) begin
            tag = "R2";
            cyc(1'b0, 8'h00, 1'b1, 8'(s));
            tag = "R3";
            wait_open();
            cyc(1'b1, b_ans(m_L), 1'b0, 8'h00);
            tag = "R4";
            wait_open();
            cyc(1'b1, b_ans(m_L), 1'b0, 8'h00);
        end

        // seed write wins over a good step in the same cycle
        tag = "R2";
        wait_open();
        cyc(1'b1, b_ans(m_L), 1'b1, 8'h33);
        idle(2);

        // correct answer during the closed half leaves the challenge alone
        tag = "R8";
        cyc(1'b1, b_ans(m_L), 1'b0, 8'h00);
        idle(1);

        tag = "R11";
        idle(20);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule